// File: doc/BRIEF.md
# Serial NOR Status and Write-Protect Controller

This block holds the status byte of a small serial NOR memory and decides, for every decoded command strobe, whether the command may run. The serial front end decodes each instruction into a one-cycle strobe with an operation code, a byte address and a data byte. This block answers with a one-cycle accept or reject flag. Write-class operations need the write-enable latch set first. Page program and every erase are checked against a protected address range taken from the top of the array. A status write is refused while the hardware lock is active, which means the lock bit is set and the write-protect pin is low.

An accepted program, erase or status write starts a down-counter loaded with a per-operation cycle count. The in-progress bit stays high until that counter expires. On that same edge the write-enable latch clears. The standby indication follows chip select and the in-progress bit.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00. Its layout is bit 7 lock bit, bits 6..5 always 0, bits 4..2 protect code, bit 1 write-enable latch, bit 0 write-in-progress.
- R2: Operation code 1 (write enable) sets the latch and operation code 2 (write disable) clears it. Both are accepted when the block is idle.
- R3: A write-class command is rejected and starts nothing while the latch is 0. The write-class codes are 3 page program, 4 sector erase, 5 half-block erase, 6 block erase, 7 chip erase and 8 status write.
- R4: Protect code 0 protects nothing and code 7 protects the whole 128 KiB array. A code n from 1 to 6 protects the top min(2^(n-1), 32) sectors of 4 KiB. A program, sector, half-block (32 KiB) or block (64 KiB) erase is rejected when its aligned range overlaps the protected range. Chip erase is rejected for any nonzero code.
- R5: While the lock bit is 1 and wp_ni is 0, a status write is rejected and bits 7..2 stay unchanged. With wp_ni high the same write is accepted.
- R6: An accepted status write loads the lock bit from data bit 7 and the protect code from data bits 4..2. Data bits 6, 5, 1 and 0 are ignored.
- R7: The in-progress bit rises in the cycle after an accepted write-class command. It stays high for exactly the cycle count configured for that operation.
- R8: The latch clears on the edge where the in-progress bit falls. It also clears on the edge after a rejected write-class command.
- R9: While the in-progress bit is 1, every command with code 1..8 is rejected. The latch, the lock bit and the protect code are left unchanged.
- R10: standby_o is high exactly when cs_ni is high and the in-progress bit is 0.
- R11: accept_o and reject_o are one-cycle pulses in the cycle after a strobe and are never both high. Code 0 and codes 9..15 raise neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 4 | Operation code |
| addr_i | input | ADDR_W | Target byte address |
| data_i | input | 8 | Status write data |
| wp_ni | input | 1 | Write-protect pin, active low |
| cs_ni | input | 1 | Chip select, active low |
| status_o | output | 8 | Status byte |
| accept_o | output | 1 | Command accepted pulse |
| reject_o | output | 1 | Command rejected pulse |
| busy_o | output | 1 | Internal write cycle running |
| standby_o | output | 1 | Standby condition |

## Verification
Every protect code from 0 to 7 is loaded in turn. Under each code, page program and all three erase sizes are aimed at every sector, and chip erase is tried once. This separates overlap errors at the boundary of the protected range from errors in how wide an erase span is taken. Each accepted operation is timed to the cycle, so a wrong per-operation count or a swapped timer load shows up. Separate sequences cover the write-enable latch being absent, commands arriving while busy, and the hardware lock with the pin at both levels. The two hardware-lock sequences show whether the lock depends on the pin or on the lock bit alone.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_WREN = 4'd1,
    OP_WRDI = 4'd2,
    OP_PP   = 4'd3,
    OP_SE   = 4'd4,
    OP_HBE  = 4'd5,
    OP_BE   = 4'd6,
    OP_CE   = 4'd7,
    OP_WRSR = 4'd8
  } wp_op_e;
endpackage

// File: rtl/flash_wp_range.sv
module flash_wp_range #(
  parameter int ADDR_W = 17,
  parameter int SECT_W = 12,
  localparam int SIDX_W = ADDR_W - SECT_W,
  localparam int NSECT  = 1 << SIDX_W
) (
  input  logic [2:0]        bp_i,
  input  logic [SIDX_W-1:0] sect_i,
  input  logic [SIDX_W-1:0] span_i,
  output logic              hit_o
);
  logic [SIDX_W:0] size_s, first_s, end_s;

  always_comb begin
    end_s = {1'b0, sect_i | span_i};
    if (int'(bp_i) - 1 >= SIDX_W || bp_i == 3'd0) size_s = (SIDX_W+1)'(NSECT);
    else size_s = (SIDX_W+1)'(1) << (bp_i - 3'd1);
    first_s = (SIDX_W+1)'(NSECT) - size_s;
    if (bp_i == 3'd0)      hit_o = 1'b0;
    else if (bp_i == 3'd7) hit_o = 1'b1;
    else                   hit_o = (end_s >= first_s);
  end
endmodule

// File: rtl/flash_wp_timer.sv
module flash_wp_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1)) && !load_i;
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int SECT_W = 12,
  parameter int HBLK_W = 15,
  parameter int BLK_W  = 16,
  parameter int T_PP   = 4,
  parameter int T_SE   = 6,
  parameter int T_HBE  = 8,
  parameter int T_BE   = 10,
  parameter int T_CE   = 12,
  parameter int T_WRSR = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [3:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              wp_ni,
  input  logic              cs_ni,
  output logic [7:0]        status_o,
  output logic              accept_o,
  output logic              reject_o,
  output logic              busy_o,
  output logic              standby_o
);
  localparam int SIDX_W = ADDR_W - SECT_W;
  localparam int T_M1 = (T_PP > T_SE) ? T_PP : T_SE;
  localparam int T_M2 = (T_HBE > T_BE) ? T_HBE : T_BE;
  localparam int T_M3 = (T_CE > T_WRSR) ? T_CE : T_WRSR;
  localparam int T_M4 = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int T_MAX = (T_M3 > T_M4) ? T_M3 : T_M4;
  localparam int CNT_W = $clog2(T_MAX + 1);

  wp_op_e op;
  logic srp_q, wel_q, accept_q, reject_q;
  logic [2:0] bp_q;
  logic busy, done, prot_hit, hw_lock, acc, rej, valid_op;
  logic [SIDX_W-1:0] span;
  logic [CNT_W-1:0] load_val;
  logic unused_bits;

  assign op = wp_op_e'(cmd_op_i);
  assign unused_bits = ^{addr_i[SECT_W-1:0], data_i[6:5], data_i[1:0]};
  assign hw_lock = srp_q && !wp_ni;
  assign valid_op = (cmd_op_i >= 4'd1) && (cmd_op_i <= 4'd8);

  always_comb begin
    unique case (op)
      OP_HBE:  span = SIDX_W'((1 << (HBLK_W - SECT_W)) - 1);
      OP_BE:   span = SIDX_W'((1 << (BLK_W - SECT_W)) - 1);
      OP_CE:   span = '1;
      default: span = '0;
    endcase
  end

  flash_wp_range #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_range (
    .bp_i   (bp_q),
    .sect_i (addr_i[ADDR_W-1:SECT_W]),
    .span_i (span),
    .hit_o  (prot_hit)
  );

  always_comb begin
    acc = 1'b0;
    rej = 1'b0;
    if (cmd_valid_i && valid_op) begin
      if (busy) rej = 1'b1;
      else begin
        unique case (op)
          OP_WREN, OP_WRDI: acc = 1'b1;
          OP_WRSR: begin
            rej = !wel_q || hw_lock;
            acc = !rej;
          end
          default: begin
            rej = !wel_q || prot_hit;
            acc = !rej;
          end
        endcase
      end
    end
  end

  always_comb begin
    unique case (op)
      OP_PP:   load_val = CNT_W'(T_PP);
      OP_SE:   load_val = CNT_W'(T_SE);
      OP_HBE:  load_val = CNT_W'(T_HBE);
      OP_BE:   load_val = CNT_W'(T_BE);
      OP_CE:   load_val = CNT_W'(T_CE);
      default: load_val = CNT_W'(T_WRSR);
    endcase
  end

  flash_wp_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (acc && op != OP_WREN && op != OP_WRDI),
    .val_i  (load_val),
    .busy_o (busy),
    .done_o (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srp_q    <= 1'b0;
      bp_q     <= '0;
      wel_q    <= 1'b0;
      accept_q <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      accept_q <= acc;
      reject_q <= rej;
      if (acc && op == OP_WREN)          wel_q <= 1'b1;
      else if (acc && op == OP_WRDI)     wel_q <= 1'b0;
      else if ((rej && !busy) || done)   wel_q <= 1'b0;
      if (acc && op == OP_WRSR) begin
        srp_q <= data_i[7];
        bp_q  <= data_i[4:2];
      end
    end
  end

  assign status_o  = {srp_q, 2'b00, bp_q, wel_q, busy};
  assign accept_o  = accept_q;
  assign reject_o  = reject_q;
  assign busy_o    = busy;
  assign standby_o = cs_ni && !busy;
endmodule

// File: rtl/flash_wp_sva.sv
module flash_wp_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic [3:0] cmd_op_i,
  input logic       wp_ni,
  input logic [7:0] status_o,
  input logic       accept_o,
  input logic       reject_o
);
  a_r11_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && reject_o));

  a_r3_no_latch_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !status_o[1] && cmd_op_i >= 4'd3 && cmd_op_i <= 4'd8) |=> reject_o);

  a_r9_busy_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && status_o[0] && cmd_op_i >= 4'd1 && cmd_op_i <= 4'd8) |=> (reject_o && !accept_o));

  a_r7_wip_needs_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> accept_o);

  a_r8_latch_clear_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[0]) |-> !status_o[1]);

  a_r5_hw_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 4'd8 && status_o[7] && !wp_ni) |=> (reject_o && $stable(status_o[7:2])));
endmodule

bind flash_wp_ctrl flash_wp_sva i_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .wp_ni       (wp_ni),
  .status_o    (status_o),
  .accept_o    (accept_o),
  .reject_o    (reject_o)
);

// File: tb/test_flash_wp_ctrl.sv
`timescale 1ns/1ps
module test_flash_wp_ctrl;
  localparam int AW = 17;
  localparam int TPP = 4, TSE = 6, THBE = 8, TBE = 10, TCE = 12, TWRSR = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, wp_n = 1'b1, cs_n = 1'b1;
  logic [3:0] cmd_op = '0;
  logic [AW-1:0] addr = '0;
  logic [7:0] data = '0;
  logic [7:0] status;
  logic acc, rej, busy, stby;
  int checks = 0, fails = 0;
  logic s_acc, s_rej;

  always #10 clk = ~clk;

  flash_wp_ctrl #(.ADDR_W(AW), .T_PP(TPP), .T_SE(TSE), .T_HBE(THBE), .T_BE(TBE),
                  .T_CE(TCE), .T_WRSR(TWRSR)) i_flash_wp_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .addr_i(addr), .data_i(data), .wp_ni(wp_n), .cs_ni(cs_n), .status_o(status),
    .accept_o(acc), .reject_o(rej), .busy_o(busy), .standby_o(stby));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] op, input int a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; addr = AW'(a); data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    s_acc = acc; s_rej = rej;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (status[0]) begin n++; @(negedge clk); end
  endtask

  function automatic int dur(input int op);
    case (op)
      3: return TPP; 4: return TSE; 5: return THBE; 6: return TBE; 7: return TCE;
      default: return TWRSR;
    endcase
  endfunction

  // R4 expected: byte-range overlap with top region
  function automatic bit protected_hit(input int bp, input int op, input int a);
    int size, lo, hi, region_lo;
    if (bp == 0) return 0;
    if (bp == 7) return 1;
    size = (1 << (bp - 1)); if (size > 32) size = 32;
    region_lo = 131072 - size * 4096;
    case (op)
      5: size = 32768; 6: size = 65536; 7: size = 131072; default: size = 4096;
    endcase
    lo = a - (a % size); hi = lo + size - 1;
    return hi >= region_lo;
  endfunction

  task automatic set_bp(input int bp);
    int n;
    cmd(4'd1, 0, 8'h00);
    cmd(4'd8, 0, 8'(bp << 2));
    wait_idle(n);
    chk(status == 8'(bp << 2), "R6 protect code load", status, bp << 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(status == 8'h00, "R1 reset status", status, 0);
    chk(!acc && !rej, "R11 no flags at reset", {acc, rej}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: no latch
    cmd(4'd4, 0, 8'h00);
    chk(s_rej && !s_acc, "R3 erase without latch rejected", {s_acc, s_rej}, 1);
    chk(status == 8'h00, "R3 nothing started", status, 0);

    // R2
    cmd(4'd1, 0, 8'h00);
    chk(s_acc && status == 8'h02, "R2 write enable", status, 2);
    cmd(4'd2, 0, 8'h00);
    chk(s_acc && status == 8'h00, "R2 write disable", status, 0);

    // R11: nop and undefined codes
    cmd(4'd0, 0, 8'h00);
    chk(!s_acc && !s_rej, "R11 nop no flag", {s_acc, s_rej}, 0);
    cmd(4'd12, 0, 8'h00);
    chk(!s_acc && !s_rej, "R11 undefined code no flag", {s_acc, s_rej}, 0);
    @(negedge clk);
    chk(!acc && !rej, "R11 flag lasts one cycle", {acc, rej}, 0);

    // R6: ignored data bits
    cmd(4'd1, 0, 8'h00);
    cmd(4'd8, 0, 8'h7F);
    chk(s_acc, "R6 status write accepted", s_rej, 0);
    wait_idle(n);
    chk(n == TWRSR, "R7 status write duration", n, TWRSR);
    chk(status == 8'h1C, "R6 reserved bits ignored", status, 8'h1C);
    set_bp(0);

    // R4/R7/R8 sweep
    for (int bp = 0; bp < 8; bp++) begin
      set_bp(bp);
      for (int op = 3; op <= 7; op++) begin
        for (int s = 0; s < 32; s++) begin
          int a;
          bit ph;
          if (op == 7 && s > 0) break;
          a = s * 4096 + (s * 37) % 4096;
          ph = protected_hit(bp, op, a);
          cmd(4'd1, 0, 8'h00);
          cmd(4'(op), a, 8'h00);
          chk(s_acc == !ph && s_rej == ph, "R4 protect decision", {s_acc, s_rej}, {!ph, ph});
          if (!ph) begin
            wait_idle(n);
            chk(n == dur(op), "R7 busy duration", n, dur(op));
          end
          chk(status[1] == 1'b0, "R8 latch cleared", status, 0);
        end
      end
    end
    set_bp(0);

    // R9 and R10
    cs_n = 1'b1;
    cmd(4'd1, 0, 8'h00);
    cmd(4'd7, 0, 8'h00);
    chk(status[0] && !stby, "R10 no standby while busy", stby, 0);
    cmd(4'd2, 0, 8'h00);
    chk(s_rej && status[1], "R9 disable ignored while busy", status, 8'h03);
    cmd(4'd8, 0, 8'h9C);
    chk(s_rej && status[7:2] == 6'd0, "R9 status write ignored while busy", status, 8'h03);
    wait_idle(n);
    chk(stby, "R10 standby when idle and deselected", stby, 1);
    cs_n = 1'b0;
    @(negedge clk);
    chk(!stby, "R10 no standby when selected", stby, 0);
    cs_n = 1'b1;

    // R5 hardware lock
    cmd(4'd1, 0, 8'h00);
    cmd(4'd8, 0, 8'h80);
    wait_idle(n);
    wp_n = 1'b0;
    cmd(4'd1, 0, 8'h00);
    cmd(4'd8, 0, 8'h0C);
    chk(s_rej && !s_acc, "R5 locked write rejected", {s_acc, s_rej}, 1);
    chk(status == 8'h80, "R5 bits unchanged", status, 8'h80);
    wp_n = 1'b1;
    cmd(4'd1, 0, 8'h00);
    cmd(4'd8, 0, 8'h0C);
    chk(s_acc, "R5 pin high allows write", s_rej, 0);
    wait_idle(n);
    chk(status == 8'h0C, "R5 write applied", status, 8'h0C);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule